// File: doc/BRIEF.md
# Floating-Point Exception Status Resolver

This block sits behind the rounding stage of a floating-point unit. Each finished operation reports its raw exception conditions: invalid, overflow, tiny result, divide-by-zero, inexact, denormal input, unfinished and unimplemented. The block combines them with the five trap-enable mask bits and the non-standard-mode bit. From these it decides whether a deferred trap is due, which code goes into the 3-bit trap-type field, which bits go into the current-exception field, and which bits are ORed into the accrued-exception field.

It also tracks the unit's trap state. After a trap is found, the unit waits in an exception-pending state until the integer side acknowledges it. It then stays in exception mode while the handler drains the queue. It returns to normal when the queue reports empty. In exception mode, an arithmetic FP instruction (anything but a store) is flagged as a sequence error. A queue-drain store issued outside exception mode is also flagged as a sequence error.

Top module: `fp_exc_resolver`

## Requirements
- R1: While reset is asserted and after it, current-exception, accrued-exception and trap-type read 0, and exc_pending and exc_mode are low.
- R2: The trap-type codes are: 000 none, 001 IEEE, 010 unfinished, 011 unimplemented, 100 sequence error. An unimplemented condition wins over unfinished, and unfinished wins over any IEEE condition. Both traps leave current- and accrued-exception unchanged.
- R3: When no trap results, current-exception is loaded with the detected flags and the same bits are ORed into accrued-exception. The bit order is nv=bit 4, of=3, uf=2, dz=1, nx=0, and the mask uses the same order. The trap type becomes 000 and nothing is pending.
- R4: An nv, of, uf or dz condition whose mask bit is set causes a trap with type 001. Current-exception then holds only that bit, and accrued-exception is unchanged.
- R5: When the non-inexact condition is masked off (or absent), inexact is present and the nx mask bit is set, the trap has type 001 and current-exception becomes 00001.
- R6: In standard mode (ns_mode=0), a tiny result or a denormal input raises an unfinished trap (type 010), and the uf bit is never reported.
- R7: In non-standard mode, a tiny result raises both the uf and nx conditions, and a denormal input (replaced by zero) raises nx.
- R8: A trap sets exc_pending on the next cycle. It stays set until exc_ack is sampled high. The unit then enters exc_mode, and exc_pending drops.
- R9: exc_mode ends, back to normal, on the cycle after queue_empty is sampled high.
- R10: In exc_mode, an fp_issue with fp_issue_store low sets the trap type to 100 and stays in exc_mode. An fp_issue with fp_issue_store high changes nothing.
- R11: A qdrain_issue in normal mode raises a sequence-error trap: type 100 and exc_pending.
- R12: Rounding-stage results that arrive while exc_pending or exc_mode is set are ignored, and all status stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rnd_vld | input | 1 | A result leaves the rounding stage this cycle |
| rnd_nv | input | 1 | Invalid-operation condition |
| rnd_of | input | 1 | Overflow condition |
| rnd_tiny | input | 1 | Result tiny before rounding |
| rnd_dz | input | 1 | Divide-by-zero condition |
| rnd_nx | input | 1 | Inexact condition |
| rnd_denorm | input | 1 | A denormal input operand was seen |
| rnd_unfin | input | 1 | Other unfinished condition |
| rnd_unimp | input | 1 | Unimplemented instruction |
| trap_mask | input | 5 | Trap-enable mask, nv..nx at bits 4..0 |
| ns_mode | input | 1 | Non-standard (flush-to-zero) mode |
| fp_issue | input | 1 | An FP instruction is decoded |
| fp_issue_store | input | 1 | The decoded FP instruction is a store |
| qdrain_issue | input | 1 | A queue-drain store is issued |
| exc_ack | input | 1 | Integer unit acknowledges the pending trap |
| queue_empty | input | 1 | FP queue has been drained |
| cexc | output | 5 | Current-exception field |
| aexc | output | 5 | Accrued-exception field |
| ftt | output | 3 | Trap-type field |
| exc_pending | output | 1 | Deferred trap awaiting acknowledge |
| exc_mode | output | 1 | Unit is in exception mode |

## Verification
The flag count and code widths are fixed in the package, so the bench builds the block with its default configuration. That configuration is small enough to sweep completely. Every combination of mode bit, the 32 mask values, each single non-inexact condition (or none), and the four modifier conditions (inexact, denormal, unfinished, unimplemented) is applied. This covers every priority path, including each mask-dependent choice between a specific flag and inexact. After every trapping case, the bench walks the pending, exception and return sequence, checks that late results are ignored, and checks both sequence-error sources.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NFLAG = 5;
  localparam int FTT_W = 3;

  localparam int B_NV = 4;
  localparam int B_OF = 3;
  localparam int B_UF = 2;
  localparam int B_DZ = 1;
  localparam int B_NX = 0;

  localparam logic [NFLAG-1:0] NX_ONLY = NFLAG'(1) << B_NX;

  typedef enum logic [FTT_W-1:0] {
    FTT_NONE  = 3'd0,
    FTT_IEEE  = 3'd1,
    FTT_UNFIN = 3'd2,
    FTT_UNIMP = 3'd3,
    FTT_SEQ   = 3'd4,
    FTT_HWERR = 3'd5
  } ftt_e;

  typedef enum logic [1:0] {
    M_NORMAL = 2'd0,
    M_PEND   = 2'd1,
    M_EXC    = 2'd2
  } mode_e;
endpackage

// File: rtl/fpx_classify.sv
module fpx_classify
  import fpx_pkg::*;
(
  input  logic             ns_mode,
  input  logic [NFLAG-1:0] mask,
  input  logic             c_nv,
  input  logic             c_of,
  input  logic             c_tiny,
  input  logic             c_dz,
  input  logic             c_nx,
  input  logic             c_denorm,
  input  logic             c_unfin,
  input  logic             c_unimp,
  output logic             trap,
  output ftt_e             ftt_code,
  output logic             cexc_we,
  output logic [NFLAG-1:0] cexc_new,
  output logic [NFLAG-1:0] acc
);
  logic [NFLAG-1:0] raw;
  logic [NFLAG-1:0] prim;
  logic [NFLAG-1:0] armed;
  logic [NFLAG-1:0] pick;
  logic             found;
  logic             unfin_hit;
  logic             nx_trap;

  always_comb begin
    raw       = '0;
    raw[B_NV] = c_nv;
    raw[B_OF] = c_of;
    raw[B_UF] = ns_mode & c_tiny;
    raw[B_DZ] = c_dz;
    raw[B_NX] = c_nx | (ns_mode & (c_denorm | c_tiny));
  end

  assign unfin_hit = c_unfin | (~ns_mode & (c_tiny | c_denorm));
  assign prim      = raw & ~NX_ONLY;
  assign armed     = prim & mask;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NFLAG-1; i >= 0; i--) begin
      if (armed[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign nx_trap = ~found & raw[B_NX] & mask[B_NX];

  always_comb begin
    trap     = 1'b0;
    ftt_code = FTT_NONE;
    cexc_we  = 1'b0;
    cexc_new = '0;
    acc      = '0;
    if (c_unimp) begin
      trap     = 1'b1;
      ftt_code = FTT_UNIMP;
    end else if (unfin_hit) begin
      trap     = 1'b1;
      ftt_code = FTT_UNFIN;
    end else if (found) begin
      trap     = 1'b1;
      ftt_code = FTT_IEEE;
      cexc_we  = 1'b1;
      cexc_new = pick;
    end else if (nx_trap) begin
      trap     = 1'b1;
      ftt_code = FTT_IEEE;
      cexc_we  = 1'b1;
      cexc_new = NX_ONLY;
    end else begin
      cexc_we  = 1'b1;
      cexc_new = raw;
      acc      = raw;
    end
  end

  // R6
  always_comb begin
    if (cexc_we && !ns_mode) begin
      std_no_uf_chk: assert (!cexc_new[B_UF]);
    end
  end
endmodule

// File: rtl/fpx_status_regs.sv
module fpx_status_regs
  import fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ftt_we,
  input  ftt_e             ftt_d,
  input  logic             cexc_we,
  input  logic [NFLAG-1:0] cexc_d,
  input  logic [NFLAG-1:0] aexc_or,
  output ftt_e             ftt_q,
  output logic [NFLAG-1:0] cexc_q,
  output logic [NFLAG-1:0] aexc_q
);
  ftt_e             ftt_n;
  logic [NFLAG-1:0] cexc_n;
  logic [NFLAG-1:0] aexc_n;

  always_comb begin
    ftt_n  = ftt_we  ? ftt_d  : ftt_q;
    cexc_n = cexc_we ? cexc_d : cexc_q;
    aexc_n = aexc_q | aexc_or;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftt_q  <= FTT_NONE;
      cexc_q <= '0;
      aexc_q <= '0;
    end else begin
      ftt_q  <= ftt_n;
      cexc_q <= cexc_n;
      aexc_q <= aexc_n;
    end
  end

  // R3
  aexc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((aexc_q & $past(aexc_q)) == $past(aexc_q)));
endmodule

// File: rtl/fpx_mode_fsm.sv
module fpx_mode_fsm
  import fpx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  trap_req,
  input  logic  ack,
  input  logic  q_empty,
  output mode_e st
);
  mode_e st_n;

  always_comb begin
    st_n = st;
    unique case (st)
      M_NORMAL: if (trap_req) st_n = M_PEND;
      M_PEND:   if (ack)      st_n = M_EXC;
      M_EXC:    if (q_empty)  st_n = M_NORMAL;
      default:                st_n = M_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= M_NORMAL;
    else        st <= st_n;
  end

  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_PEND && !ack) |=> (st == M_PEND));
  // R9
  exc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_EXC && !q_empty) |=> (st == M_EXC));
endmodule

// File: rtl/fp_exc_resolver.sv
module fp_exc_resolver
  import fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rnd_vld,
  input  logic             rnd_nv,
  input  logic             rnd_of,
  input  logic             rnd_tiny,
  input  logic             rnd_dz,
  input  logic             rnd_nx,
  input  logic             rnd_denorm,
  input  logic             rnd_unfin,
  input  logic             rnd_unimp,
  input  logic [NFLAG-1:0] trap_mask,
  input  logic             ns_mode,
  input  logic             fp_issue,
  input  logic             fp_issue_store,
  input  logic             qdrain_issue,
  input  logic             exc_ack,
  input  logic             queue_empty,
  output logic [NFLAG-1:0] cexc,
  output logic [NFLAG-1:0] aexc,
  output logic [FTT_W-1:0] ftt,
  output logic             exc_pending,
  output logic             exc_mode
);
  mode_e            st;
  logic             cls_trap;
  ftt_e             cls_ftt;
  logic             cls_cexc_we;
  logic [NFLAG-1:0] cls_cexc;
  logic [NFLAG-1:0] cls_acc;
  logic             in_norm;
  logic             take_rnd;
  logic             seq_norm;
  logic             seq_exc;
  logic             trap_req;
  logic             ftt_we;
  ftt_e             ftt_d;
  logic             cexc_we;
  logic [NFLAG-1:0] aexc_or;
  ftt_e             ftt_q;

  fpx_classify u_cls (
    .ns_mode  (ns_mode),
    .mask     (trap_mask),
    .c_nv     (rnd_nv),
    .c_of     (rnd_of),
    .c_tiny   (rnd_tiny),
    .c_dz     (rnd_dz),
    .c_nx     (rnd_nx),
    .c_denorm (rnd_denorm),
    .c_unfin  (rnd_unfin),
    .c_unimp  (rnd_unimp),
    .trap     (cls_trap),
    .ftt_code (cls_ftt),
    .cexc_we  (cls_cexc_we),
    .cexc_new (cls_cexc),
    .acc      (cls_acc)
  );

  always_comb begin
    in_norm  = (st == M_NORMAL);
    take_rnd = in_norm & rnd_vld;
    seq_norm = in_norm & qdrain_issue & ~(take_rnd & cls_trap);
    seq_exc  = (st == M_EXC) & fp_issue & ~fp_issue_store;
    trap_req = (take_rnd & cls_trap) | seq_norm;
    ftt_we   = take_rnd | seq_norm | seq_exc;
    ftt_d    = (seq_norm | seq_exc) ? FTT_SEQ : cls_ftt;
    cexc_we  = take_rnd & cls_cexc_we;
    aexc_or  = take_rnd ? cls_acc : '0;
  end

  fpx_status_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .ftt_we  (ftt_we),
    .ftt_d   (ftt_d),
    .cexc_we (cexc_we),
    .cexc_d  (cls_cexc),
    .aexc_or (aexc_or),
    .ftt_q   (ftt_q),
    .cexc_q  (cexc),
    .aexc_q  (aexc)
  );

  fpx_mode_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .trap_req (trap_req),
    .ack      (exc_ack),
    .q_empty  (queue_empty),
    .st       (st)
  );

  assign ftt         = ftt_q;
  assign exc_pending = (st == M_PEND);
  assign exc_mode    = (st == M_EXC);

  // R4
  ieee_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ftt_q == FTT_IEEE) |-> $onehot(cexc));
  // R8
  pend_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pending |-> (ftt_q != FTT_NONE));
  // R2
  trap_aexc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_rnd && cls_trap) |=> $stable(aexc));
  // R12
  late_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_norm && !seq_exc) |=> ($stable(cexc) && $stable(aexc) && $stable(ftt_q)));
endmodule

// File: tb/tb_fp_exc_resolver.sv
`timescale 1ns/1ps
module tb_fp_exc_resolver;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rnd_vld, rnd_nv, rnd_of, rnd_tiny, rnd_dz, rnd_nx;
  logic       rnd_denorm, rnd_unfin, rnd_unimp;
  logic [4:0] trap_mask;
  logic       ns_mode, fp_issue, fp_issue_store, qdrain_issue, exc_ack, queue_empty;
  logic [4:0] cexc, aexc;
  logic [2:0] ftt;
  logic       exc_pending, exc_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  fp_exc_resolver dut (
    .clk(clk), .rst_n(rst_n), .rnd_vld(rnd_vld), .rnd_nv(rnd_nv), .rnd_of(rnd_of),
    .rnd_tiny(rnd_tiny), .rnd_dz(rnd_dz), .rnd_nx(rnd_nx), .rnd_denorm(rnd_denorm),
    .rnd_unfin(rnd_unfin), .rnd_unimp(rnd_unimp), .trap_mask(trap_mask),
    .ns_mode(ns_mode), .fp_issue(fp_issue), .fp_issue_store(fp_issue_store),
    .qdrain_issue(qdrain_issue), .exc_ack(exc_ack), .queue_empty(queue_empty),
    .cexc(cexc), .aexc(aexc), .ftt(ftt), .exc_pending(exc_pending), .exc_mode(exc_mode)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    rnd_vld = 0; rnd_nv = 0; rnd_of = 0; rnd_tiny = 0; rnd_dz = 0; rnd_nx = 0;
    rnd_denorm = 0; rnd_unfin = 0; rnd_unimp = 0;
    fp_issue = 0; fp_issue_store = 0; qdrain_issue = 0; exc_ack = 0; queue_empty = 0;
  endtask

  logic [4:0] m_cexc, m_aexc;
  logic [2:0] m_ftt;

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    #2;
    chk("R1", "cexc", cexc, 0);
    chk("R1", "aexc", aexc, 0);
    chk("R1", "ftt", ftt, 0);
    chk("R1", "pending", exc_pending, 0);
    chk("R1", "mode", exc_mode, 0);
    @(negedge clk);
    rst_n = 1;
    m_cexc = 0; m_aexc = 0; m_ftt = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int idx;
    idle();
    trap_mask = 0; ns_mode = 0;
    rst_n = 0;
    m_cexc = 0; m_aexc = 0; m_ftt = 0;
    do_reset();
    idx = 0;
    for (int ns = 0; ns < 2; ns++) begin
      for (int mk = 0; mk < 32; mk++) begin
        for (int pr = 0; pr < 5; pr++) begin
          for (int v = 0; v < 16; v++) begin
            bit nx, den, unf, uni, trap;
            logic [4:0] fl;
            int bitp;
            string tag;
            nx = v[0]; den = v[1]; unf = v[2]; uni = v[3];
            if (idx % 4 == 0) do_reset();
            idx++;
            // expected model
            bitp = 5 - pr;
            trap = 0;
            if (uni) begin
              trap = 1; m_ftt = 3; tag = "R2";
            end else if (unf || (ns == 0 && (pr == 3 || den))) begin
              trap = 1; m_ftt = 2;
              tag = (!unf) ? "R6" : "R2";
            end else begin
              fl = 0;
              if (pr != 0) fl[bitp] = 1'b1;
              fl[0] = nx | (ns == 1 && den) | (pr == 3);
              if (pr != 0 && mk[bitp]) begin
                trap = 1; m_ftt = 1; m_cexc = 5'd1 << bitp; tag = "R4";
              end else if (fl[0] && mk[0]) begin
                trap = 1; m_ftt = 1; m_cexc = 5'd1; tag = "R5";
              end else begin
                m_ftt = 0; m_cexc = fl; m_aexc = m_aexc | fl; tag = "R3";
              end
              if (ns == 1 && (den || pr == 3)) tag = {tag, "/R7"};
            end
            ns_mode = ns[0]; trap_mask = mk[4:0];
            rnd_vld = 1; rnd_nv = (pr == 1); rnd_of = (pr == 2); rnd_tiny = (pr == 3);
            rnd_dz = (pr == 4); rnd_nx = nx; rnd_denorm = den; rnd_unfin = unf; rnd_unimp = uni;
            step();
            idle();
            chk(tag, "cexc", cexc, m_cexc);
            chk(tag, "aexc", aexc, m_aexc);
            chk(tag, "ftt", ftt, m_ftt);
            chk("R8", "pending after result", exc_pending, trap);
            if (trap) begin
              // late result while pending, no ack
              rnd_vld = 1; rnd_nv = 1; rnd_nx = 1; trap_mask = 0;
              step();
              idle();
              chk("R8", "pending held", exc_pending, 1);
              chk("R12", "cexc while pending", cexc, m_cexc);
              chk("R12", "aexc while pending", aexc, m_aexc);
              exc_ack = 1;
              step();
              idle();
              chk("R8", "exc_mode after ack", exc_mode, 1);
              chk("R8", "pending after ack", exc_pending, 0);
              rnd_vld = 1; rnd_dz = 1;
              step();
              idle();
              chk("R12", "aexc in exc_mode", aexc, m_aexc);
              chk("R12", "ftt in exc_mode", ftt, m_ftt);
              fp_issue = 1; fp_issue_store = 1;
              step();
              idle();
              chk("R10", "ftt after store", ftt, m_ftt);
              chk("R10", "mode after store", exc_mode, 1);
              if (idx % 3 == 0) begin
                fp_issue = 1;
                step();
                idle();
                m_ftt = 4;
                chk("R10", "ftt seq error", ftt, 4);
                chk("R10", "mode after seq error", exc_mode, 1);
              end
              queue_empty = 1;
              step();
              idle();
              chk("R9", "mode after drain", exc_mode, 0);
              chk("R9", "pending after drain", exc_pending, 0);
            end
          end
        end
      end
    end
    // R11: queue-drain in normal mode
    do_reset();
    qdrain_issue = 1;
    step();
    idle();
    chk("R11", "ftt", ftt, 4);
    chk("R11", "pending", exc_pending, 1);
    chk("R11", "cexc", cexc, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule